// File: doc/BRIEF.md
# Integer ALU with Immediate Extender

This block is the arithmetic and logic stage of a load-store RISC datapath. It is purely combinational. It takes operand A and a second operand. The second operand is either a register value or a 16-bit instruction constant widened to 32 bits. A 4-bit operation code selects the function. The block returns a 32-bit result, a flag that is high when the result is zero, and a signed-overflow flag.

The immediate extender sits in front of the second operand. A 2-bit mode input picks one of four sources:

- the register operand,
- the constant sign-extended,
- the constant zero-extended,
- the constant moved into the upper half with the lower half cleared.

The decoder drives the mode from the instruction class. Arithmetic and compare immediates use sign extension. Bitwise immediates use zero extension. Load-upper uses the upper placement together with the pass-B operation.

The operation set has signed and unsigned forms of add, subtract and set-on-less-than. Only the signed add and signed subtract can report overflow. The unsigned forms and the compares never do.

Top module: `risc_alu`

## Requirements
- R1: Op 0 (signed add) and op 1 (unsigned add) return A + B modulo 2^32.
- R2: Op 2 (signed subtract) and op 3 (unsigned subtract) return A - B modulo 2^32.
- R3: Op 4 returns A AND B, op 5 returns A OR B, op 6 returns NOT(A OR B), and op 7 returns A XOR B.
- R4: Op 8 returns 1 when A is less than B as two's complement numbers and 0 otherwise. This holds even when A - B overflows.
- R5: Op 9 returns 1 when A is less than B as unsigned numbers and 0 otherwise.
- R6: For op 0, the overflow flag is 1 exactly when A and B have the same sign bit and the result's sign bit differs from it.
- R7: For op 2, the overflow flag is 1 exactly when A and B have different sign bits and the result's sign bit differs from A's.
- R8: For every op other than 0 and 2, the overflow flag is 0.
- R9: The zero flag is 1 exactly when the 32-bit result is zero.
- R10: Mode 1 makes B the 16-bit constant sign-extended to 32 bits. Mode 0 makes B the register operand.
- R11: Mode 2 makes B the 16-bit constant zero-extended to 32 bits.
- R12: Mode 3 makes B the constant in bits [31:16] with bits [15:0] cleared. Op 10 (pass B) returns B unchanged, so mode 3 with op 10 performs load-upper.
- R13: Op codes 11 to 15 return a zero result with the overflow flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | Operand A |
| regb_i | input | 32 | Register value used as B in mode 0 |
| imm_i | input | 16 | Instruction constant |
| imm_mode_i | input | 2 | B source: 0 register, 1 sign-ext, 2 zero-ext, 3 upper |
| op_i | input | 4 | Operation code |
| result_o | output | 32 | Result |
| zero_o | output | 1 | Result equals zero |
| ovf_o | output | 1 | Signed overflow of op 0 or op 2 |

## Verification
Add and subtract are tried on operand pairs that sit at the signed limits: both positive, both negative, and mixed signs.

- These pairs separate a true overflow from a mere carry out of bit 31.
- They also show that the unsigned forms stay silent on the same values.

The compares use pairs where A - B overflows, such as the most negative value against a positive number. On such pairs a compare that reads only the difference's sign would give the wrong answer.

Each immediate is applied in all three extension modes, using constants with bit 15 set and with bit 15 clear. This distinguishes sign extension, zero extension and upper placement from one another.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam logic [3:0] OP_ADD   = 4'd0;
  localparam logic [3:0] OP_ADDU  = 4'd1;
  localparam logic [3:0] OP_SUB   = 4'd2;
  localparam logic [3:0] OP_SUBU  = 4'd3;
  localparam logic [3:0] OP_AND   = 4'd4;
  localparam logic [3:0] OP_OR    = 4'd5;
  localparam logic [3:0] OP_NOR   = 4'd6;
  localparam logic [3:0] OP_XOR   = 4'd7;
  localparam logic [3:0] OP_SLT   = 4'd8;
  localparam logic [3:0] OP_SLTU  = 4'd9;
  localparam logic [3:0] OP_PASSB = 4'd10;

  typedef enum logic [1:0] {
    IMM_REG   = 2'd0,
    IMM_SEXT  = 2'd1,
    IMM_ZEXT  = 2'd2,
    IMM_UPPER = 2'd3
  } imm_mode_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_NOR = 2'd2,
    LG_XOR = 2'd3
  } logic_sel_e;

  // Signed overflow of a + b from the three sign bits.
  function automatic logic add_ovf(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  // Signed overflow of a - b from the three sign bits.
  function automatic logic sub_ovf(input logic sa, input logic sb, input logic sr);
    return (sa != sb) && (sr != sa);
  endfunction

  // Signed less-than from the difference sign, corrected by overflow.
  function automatic logic signed_lt(input logic diff_sign, input logic ovf);
    return diff_sign ^ ovf;
  endfunction
endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic [1:0]       mode_i,
  input  logic [XLEN-1:0]  reg_i,
  output logic [XLEN-1:0]  b_o
);
  import alu_pkg::*;
  localparam int unsigned PAD_W = XLEN - IMM_W;

  logic [XLEN-1:0] sext_w, zext_w, upper_w;

  assign sext_w  = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
  assign zext_w  = {{PAD_W{1'b0}}, imm_i};
  assign upper_w = {imm_i, {PAD_W{1'b0}}};

  always_comb begin
    unique case (imm_mode_e'(mode_i))
      IMM_SEXT:  b_o = sext_w;
      IMM_ZEXT:  b_o = zext_w;
      IMM_UPPER: b_o = upper_w;
      default:   b_o = reg_i;
    endcase
  end

  always_comb begin
    // R12
    upper_low_clear_chk: assert (mode_i != 2'd3 || b_o[PAD_W-1:0] == '0);
    // R11
    zext_high_clear_chk: assert (mode_i != 2'd2 || b_o[XLEN-1:IMM_W] == '0);
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] sum_o,
  output logic            carry_o,
  output logic            sovf_o
);
  import alu_pkg::*;

  logic [XLEN-1:0] b_eff;
  assign b_eff = sub_i ? ~b_i : b_i;
  assign {carry_o, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub_i};

  assign sovf_o = sub_i ? sub_ovf(a_i[XLEN-1], b_i[XLEN-1], sum_o[XLEN-1])
                        : add_ovf(a_i[XLEN-1], b_i[XLEN-1], sum_o[XLEN-1]);

  always_comb begin
    // R6
    add_ovf_sign_chk: assert (sub_i || !sovf_o || (a_i[XLEN-1] == b_i[XLEN-1]));
    // R7
    sub_ovf_sign_chk: assert (!sub_i || !sovf_o || (a_i[XLEN-1] != b_i[XLEN-1]));
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [1:0]      sel_i,
  output logic [XLEN-1:0] y_o
);
  import alu_pkg::*;

  always_comb begin
    unique case (logic_sel_e'(sel_i))
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      LG_NOR:  y_o = ~(a_i | b_i);
      default: y_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/risc_alu.sv
module risc_alu #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [XLEN-1:0]  opa_i,
  input  logic [XLEN-1:0]  regb_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [1:0]       imm_mode_i,
  input  logic [3:0]       op_i,
  output logic [XLEN-1:0]  result_o,
  output logic             zero_o,
  output logic             ovf_o
);
  import alu_pkg::*;

  logic [XLEN-1:0] opb_w, sum_w, logic_w;
  logic            carry_w, sovf_w, do_sub_w;
  logic            slt_w, sltu_w;

  alu_imm_ext #(.XLEN(XLEN), .IMM_W(IMM_W)) u_imm (
    .imm_i (imm_i),
    .mode_i(imm_mode_i),
    .reg_i (regb_i),
    .b_o   (opb_w)
  );

  assign do_sub_w = (op_i == OP_SUB) || (op_i == OP_SUBU) ||
                    (op_i == OP_SLT) || (op_i == OP_SLTU);

  alu_addsub #(.XLEN(XLEN)) u_addsub (
    .a_i    (opa_i),
    .b_i    (opb_w),
    .sub_i  (do_sub_w),
    .sum_o  (sum_w),
    .carry_o(carry_w),
    .sovf_o (sovf_w)
  );

  alu_logic #(.XLEN(XLEN)) u_logic (
    .a_i  (opa_i),
    .b_i  (opb_w),
    .sel_i(op_i[1:0]),
    .y_o  (logic_w)
  );

  // Compare events brought out for checking.
  assign slt_w  = signed_lt(sum_w[XLEN-1], sovf_w);
  assign sltu_w = ~carry_w;

  always_comb begin
    result_o = '0;
    ovf_o    = 1'b0;
    unique case (op_i)
      OP_ADD:  begin result_o = sum_w; ovf_o = sovf_w; end
      OP_SUB:  begin result_o = sum_w; ovf_o = sovf_w; end
      OP_ADDU, OP_SUBU: result_o = sum_w;
      OP_AND, OP_OR, OP_NOR, OP_XOR: result_o = logic_w;
      OP_SLT:  result_o = {{(XLEN-1){1'b0}}, slt_w};
      OP_SLTU: result_o = {{(XLEN-1){1'b0}}, sltu_w};
      OP_PASSB: result_o = opb_w;
      default: result_o = '0;
    endcase
  end

  assign zero_o = (result_o == '0);

  always_comb begin
    // R4
    slt_signed_chk: assert (op_i != OP_SLT || slt_w == ($signed(opa_i) < $signed(opb_w)));
    // R5
    sltu_unsigned_chk: assert (op_i != OP_SLTU || sltu_w == (opa_i < opb_w));
    // R8
    no_overflow_chk: assert (!ovf_o || op_i == OP_ADD || op_i == OP_SUB);
    // R9
    zero_flag_chk: assert (!zero_o || $countones(result_o) == 0);
    // R13
    undef_op_chk: assert (op_i <= OP_PASSB || result_o == '0);
  end
endmodule

// File: tb/test_risc_alu.sv
module test_risc_alu;
  logic        clk = 1'b0;
  logic [31:0] opa, regb;
  logic [15:0] imm;
  logic [1:0]  mode;
  logic [3:0]  op;
  logic [31:0] result;
  logic        zero, ovf;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  risc_alu i_risc_alu (
    .opa_i(opa), .regb_i(regb), .imm_i(imm), .imm_mode_i(mode), .op_i(op),
    .result_o(result), .zero_o(zero), .ovf_o(ovf)
  );

  function automatic logic [31:0] model_b(logic [1:0] m, logic [31:0] r, logic [15:0] k);
    case (m)
      2'd1: return 32'($signed(k));
      2'd2: return {16'h0000, k};
      2'd3: return {k, 16'h0000};
      default: return r;
    endcase
  endfunction

  // returns {ovf, result}
  function automatic logic [32:0] model(logic [3:0] o, logic [31:0] a, logic [31:0] b);
    longint sa, sb, s;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (o)
      4'd0: begin s = sa + sb; return {(s > 64'sd2147483647 || s < -64'sd2147483648), 32'(a + b)}; end
      4'd1: return {1'b0, 32'(a + b)};
      4'd2: begin s = sa - sb; return {(s > 64'sd2147483647 || s < -64'sd2147483648), 32'(a - b)}; end
      4'd3: return {1'b0, 32'(a - b)};
      4'd4: return {1'b0, a & b};
      4'd5: return {1'b0, a | b};
      4'd6: return {1'b0, ~(a | b)};
      4'd7: return {1'b0, a ^ b};
      4'd8: return {1'b0, 31'd0, sa < sb};
      4'd9: return {1'b0, 31'd0, a < b};
      4'd10: return {1'b0, b};
      default: return 33'd0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp, string what);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic run(string req, logic [3:0] o, logic [31:0] a, logic [1:0] m,
                     logic [31:0] r, logic [15:0] k);
    logic [32:0] e;
    @(negedge clk);
    op = o; opa = a; mode = m; regb = r; imm = k;
    #1;
    e = model(o, a, model_b(m, r, k));
    chk(req, result, e[31:0], "result");
    chk(req, {31'd0, ovf}, {31'd0, e[32]}, "ovf");
    chk("R9", {31'd0, zero}, {31'd0, (e[31:0] == 32'd0)}, "zero");
  endtask

  task automatic t_idle;
    run("R1", 4'd0, 32'd0, 2'd0, 32'd0, 16'd0);
    chk("R9", {31'd0, zero}, 32'd1, "idle zero");
  endtask

  task automatic t_add;
    run("R1", 4'd0, 32'd7, 2'd0, 32'd9, 16'd0);
    run("R1", 4'd1, 32'hFFFF_FFFF, 2'd0, 32'd1, 16'd0);
    run("R1", 4'd0, 32'hFFFF_FFFF, 2'd0, 32'd1, 16'd0);
  endtask

  task automatic t_sub;
    run("R2", 4'd2, 32'd5, 2'd0, 32'd5, 16'd0);
    run("R2", 4'd3, 32'd3, 2'd0, 32'd5, 16'd0);
  endtask

  task automatic t_logic;
    for (int i = 4; i < 8; i++) begin
      run("R3", 4'(i), 32'hF0F0_1234, 2'd0, 32'hFF00_5678, 16'd0);
    end
  endtask

  task automatic t_slt;
    run("R4", 4'd8, 32'h8000_0000, 2'd0, 32'd1, 16'd0);
    run("R4", 4'd8, 32'h7FFF_FFFF, 2'd0, 32'hFFFF_FFFF, 16'd0);
    run("R4", 4'd8, 32'hFFFF_FFFE, 2'd0, 32'hFFFF_FFFF, 16'd0);
    run("R4", 4'd8, 32'd4, 2'd0, 32'd4, 16'd0);
  endtask

  task automatic t_sltu;
    run("R5", 4'd9, 32'd1, 2'd0, 32'h8000_0000, 16'd0);
    run("R5", 4'd9, 32'hFFFF_FFFF, 2'd0, 32'd0, 16'd0);
    run("R5", 4'd9, 32'd3, 2'd1, 32'd0, 16'hFFFF);
  endtask

  task automatic t_ovf;
    run("R6", 4'd0, 32'h7FFF_FFFF, 2'd0, 32'd1, 16'd0);
    chk("R6", {31'd0, ovf}, 32'd1, "pos+pos");
    run("R6", 4'd0, 32'h8000_0000, 2'd0, 32'hFFFF_FFFF, 16'd0);
    chk("R6", {31'd0, ovf}, 32'd1, "neg+neg");
    run("R6", 4'd0, 32'h8000_0000, 2'd0, 32'h7FFF_FFFF, 16'd0);
    run("R7", 4'd2, 32'h8000_0000, 2'd0, 32'd1, 16'd0);
    chk("R7", {31'd0, ovf}, 32'd1, "neg-pos");
    run("R7", 4'd2, 32'h7FFF_FFFF, 2'd0, 32'hFFFF_FFFF, 16'd0);
    run("R7", 4'd2, 32'hFFFF_FFFF, 2'd0, 32'hFFFF_FFFF, 16'd0);
    run("R8", 4'd1, 32'h7FFF_FFFF, 2'd0, 32'd1, 16'd0);
    chk("R8", {31'd0, ovf}, 32'd0, "addu silent");
    run("R8", 4'd3, 32'h8000_0000, 2'd0, 32'd1, 16'd0);
    chk("R8", {31'd0, ovf}, 32'd0, "subu silent");
    run("R8", 4'd8, 32'h8000_0000, 2'd0, 32'd1, 16'd0);
  endtask

  task automatic t_imm;
    run("R10", 4'd10, 32'd0, 2'd1, 32'hDEAD_BEEF, 16'h8001);
    chk("R10", result, 32'hFFFF_8001, "sext neg");
    run("R10", 4'd10, 32'd0, 2'd1, 32'hDEAD_BEEF, 16'h1234);
    run("R10", 4'd10, 32'd0, 2'd0, 32'hDEAD_BEEF, 16'h1234);
    run("R10", 4'd0, 32'd10, 2'd1, 32'd0, 16'hFFFF);
    run("R11", 4'd10, 32'd0, 2'd2, 32'hDEAD_BEEF, 16'h8001);
    chk("R11", result, 32'h0000_8001, "zext");
    run("R11", 4'd5, 32'hAB00_0000, 2'd2, 32'd0, 16'hF00F);
    run("R12", 4'd10, 32'h1111_1111, 2'd3, 32'hDEAD_BEEF, 16'hAAAA);
    chk("R12", result, 32'hAAAA_0000, "upper");
    run("R12", 4'd5, 32'h0000_5555, 2'd3, 32'd0, 16'hAAAA);
  endtask

  task automatic t_undef;
    for (int i = 11; i < 16; i++) begin
      run("R13", 4'(i), 32'h7FFF_FFFF, 2'd0, 32'd1, 16'd0);
    end
  endtask

  initial begin
    op = 4'd0; opa = '0; regb = '0; imm = '0; mode = 2'd0;
    repeat (2) @(posedge clk);
    t_idle();
    t_add();
    t_sub();
    t_logic();
    t_slt();
    t_sltu();
    t_ovf();
    t_imm();
    t_undef();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule